// File: doc/BRIEF.md
# Tag-Propagating Shadow Logic Unit

This block computes a bitwise AND, OR or XOR of two operand vectors and, alongside every data bit, carries a small vector of tag bits that record where information came from. An output bit inherits a tag from an operand bit only when that operand bit could have changed the output, given the value of the other operand bit. Tags are grouped by a static map. A tag is not blocked by a controlling value on the other input when that other input carries any tag of the same group.

After the logic stage, an injection stage can force one selected tag on or off per data bit, with set winning over clear. Two query outputs report whether a selected tag is present on each bit: one after injection and one before it, so the overwritten view and the original view can both be seen. An optional output register captures data, tags and the pre-injection tags together. Typical use is shadow hardware for information-flow checking: tag secret or faulty values at their source and watch whether the tags reach places they must not.

Top module: `tagflow_unit`

## Requirements
- R1: The opcode selects the data function. 2'b00 gives AND, 2'b01 gives OR and 2'b10 gives XOR. The unrecognised code 2'b11 drives data bits to 0. Tag t of data bit i sits at tag-bus index i*NT+t.
- R2: Under XOR, every tag on either operand bit appears on the result bit.
- R3: Under AND, a tag on one operand bit is forwarded only when the other operand bit is 1, or when the R5 group rule applies.
- R4: Under OR, a tag on one operand bit is forwarded only when the other operand bit is 0, or when the R5 group rule applies.
- R5: A tag is forwarded regardless of the other operand's value when the other operand bit carries any tag of the same group. Tag t belongs to the group in field TAG_GROUPS[t*GB +: GB].
- R6: A tag whose group is not present on the other operand bit is still blocked by a controlling value, even when tags of another group pass on that bit.
- R7: Under the unrecognised opcode, every tag present on any bit of either operand appears on every output bit.
- R8: On each bit whose set-mask bit is 1, the injection stage adds the selected tag. Data and all other tags pass through unchanged.
- R9: On each bit whose clear-mask bit is 1 and set-mask bit is 0, the selected tag is removed. When both mask bits are 1, the tag is present.
- R10: The post-injection query bit i is 1 exactly when the queried tag is present on output bit i, whatever that bit's data value.
- R11: The pre-injection query bit i reports the queried tag on bit i as it was before the set/clear stage.
- R12: With REG_OUT=1, outputs reflect the inputs applied before the most recent clock edge and do not follow inputs between edges. A synchronous reset clears data, tags and both queries to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Operation code (see R1) |
| a_data | input | W | Operand A data bits |
| a_tags | input | W*NT | Operand A tags, bit i tag t at i*NT+t |
| b_data | input | W | Operand B data bits |
| b_tags | input | W*NT | Operand B tags, same layout |
| inj_sel | input | SW | Index of the tag the injection stage acts on |
| inj_set | input | W | Per-bit set mask for the selected tag |
| inj_clr | input | W | Per-bit clear mask for the selected tag |
| qry_sel | input | SW | Index of the tag both queries report |
| y_data | output | W | Result data |
| y_tags | output | W*NT | Result tags after injection |
| q_now | output | W | Queried tag per bit, after injection |
| q_orig | output | W | Queried tag per bit, before injection |

## Verification
A wrong blocking or group term in this block shows up as a missing or extra tag on exactly one output bit. With the output register in place, it appears one clock after the operands are applied. The pre-injection query exposes gate errors even when injection would have masked them. The post-injection query and the tag bus together expose errors in set/clear priority in the same cycle. The sweep walks every combination of data bits and tag sets for one bit under each opcode, while other bits carry shifted patterns, so an error tied to a bit position or a group boundary is hit within a few hundred vectors.

// File: rtl/tagflow_pkg.sv
package tagflow_pkg;
   typedef enum logic [1:0] {
      TF_AND  = 2'b00,
      TF_OR   = 2'b01,
      TF_XOR  = 2'b10,
      TF_RSVD = 2'b11
   } tf_op_e;
endpackage

// File: rtl/tagflow_gate.sv
module tagflow_gate
   import tagflow_pkg::*;
#(
   parameter int W  = 4,
   parameter int NT = 4,
   parameter int GB = 2,
   parameter logic [NT*GB-1:0] TAG_GROUPS = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  tf_op_e          op,
   input  logic [W-1:0]    a_data,
   input  logic [W*NT-1:0] a_tags,
   input  logic [W-1:0]    b_data,
   input  logic [W*NT-1:0] b_tags,
   output logic [W-1:0]    y_data,
   output logic [W*NT-1:0] y_tags
);
   // tags sharing a group with tag t
   function automatic logic [NT-1:0] peers_of(input int t);
      logic [NT-1:0] m;
      for (int u = 0; u < NT; u++)
         m[u] = (TAG_GROUPS[u*GB +: GB] == TAG_GROUPS[t*GB +: GB]);
      return m;
   endfunction

   logic [NT-1:0] any_tags;
   always_comb begin
      any_tags = '0;
      for (int i = 0; i < W; i++)
         any_tags |= a_tags[i*NT +: NT] | b_tags[i*NT +: NT];
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic          ad, bd, a_open, b_open;
      logic [NT-1:0] at, bt, fwd;
      assign ad = a_data[i];
      assign bd = b_data[i];
      assign at = a_tags[i*NT +: NT];
      assign bt = b_tags[i*NT +: NT];

      always_comb begin
         unique case (op)
            TF_AND:  begin a_open = bd;   b_open = ad;   y_data[i] = ad & bd; end
            TF_OR:   begin a_open = !bd;  b_open = !ad;  y_data[i] = ad | bd; end
            TF_XOR:  begin a_open = 1'b1; b_open = 1'b1; y_data[i] = ad ^ bd; end
            default: begin a_open = 1'b1; b_open = 1'b1; y_data[i] = 1'b0;    end
         endcase
      end

      for (genvar t = 0; t < NT; t++) begin : g_tag
         localparam logic [NT-1:0] PEERS = peers_of(t);
         assign fwd[t] = (at[t] & (a_open | (|(bt & PEERS))))
                       | (bt[t] & (b_open | (|(at & PEERS))));
      end

      assign y_tags[i*NT +: NT] = (op == TF_RSVD) ? any_tags : fwd;
   end

   // R3
   no_phantom_tag_chk: assert property (@(posedge clk) disable iff (rst)
      (op != TF_RSVD) |-> ((y_tags & ~(a_tags | b_tags)) == '0));

   // R2
   xor_keeps_all_chk: assert property (@(posedge clk) disable iff (rst)
      (op == TF_XOR) |-> (((a_tags | b_tags) & ~y_tags) == '0));

   // R7
   rsvd_spread_chk: assert property (@(posedge clk) disable iff (rst)
      (op == TF_RSVD) |-> (y_tags[NT-1:0] == y_tags[W*NT-1 -: NT]) && (y_data == '0));
endmodule

// File: rtl/tagflow_inject.sv
module tagflow_inject #(
   parameter int W  = 4,
   parameter int NT = 4,
   parameter int SW = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [SW-1:0]   sel,
   input  logic [W-1:0]    set_m,
   input  logic [W-1:0]    clr_m,
   input  logic [W-1:0]    in_data,
   input  logic [W*NT-1:0] in_tags,
   output logic [W-1:0]    out_data,
   output logic [W*NT-1:0] out_tags
);
   assign out_data = in_data;

   for (genvar i = 0; i < W; i++) begin : g_bit
      for (genvar t = 0; t < NT; t++) begin : g_tag
         assign out_tags[i*NT+t] = (sel == SW'(t))
            ? (set_m[i] | (~clr_m[i] & in_tags[i*NT+t]))
            : in_tags[i*NT+t];
      end

      // R8
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
         set_m[i] |-> out_tags[i*NT + 32'(sel)]);

      // R9
      clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
         (clr_m[i] && !set_m[i]) |-> !out_tags[i*NT + 32'(sel)]);
   end
endmodule

// File: rtl/tagflow_query.sv
module tagflow_query #(
   parameter int W  = 4,
   parameter int NT = 4,
   parameter int SW = 2
) (
   input  logic [W*NT-1:0] tags,
   input  logic [SW-1:0]   sel,
   output logic [W-1:0]    hit
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign hit[i] = tags[i*NT + 32'(sel)];
   end
endmodule

// File: rtl/tagflow_unit.sv
module tagflow_unit
   import tagflow_pkg::*;
#(
   parameter int W       = 4,
   parameter int NT      = 4,
   parameter int GB      = 2,
   parameter logic [NT*GB-1:0] TAG_GROUPS = 8'h50,
   parameter bit REG_OUT = 1'b1,
   parameter int SW      = (NT > 1) ? $clog2(NT) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [1:0]      op,
   input  logic [W-1:0]    a_data,
   input  logic [W*NT-1:0] a_tags,
   input  logic [W-1:0]    b_data,
   input  logic [W*NT-1:0] b_tags,
   input  logic [SW-1:0]   inj_sel,
   input  logic [W-1:0]    inj_set,
   input  logic [W-1:0]    inj_clr,
   input  logic [SW-1:0]   qry_sel,
   output logic [W-1:0]    y_data,
   output logic [W*NT-1:0] y_tags,
   output logic [W-1:0]    q_now,
   output logic [W-1:0]    q_orig
);
   if (W < 1 || NT < 1 || GB < 1) begin : g_bad_size
      $error("tagflow_unit: W, NT and GB must be at least 1");
   end
   if (SW < 1 || (1 << SW) < NT) begin : g_bad_sel
      $error("tagflow_unit: SW too narrow to index NT tags");
   end

   tf_op_e          op_e;
   logic [W-1:0]    raw_data, fin_data;
   logic [W*NT-1:0] raw_tags, fin_tags, org_tags;

   assign op_e = tf_op_e'(op);

   tagflow_gate #(.W(W), .NT(NT), .GB(GB), .TAG_GROUPS(TAG_GROUPS)) u_gate (
      .clk(clk), .rst(rst), .op(op_e),
      .a_data(a_data), .a_tags(a_tags), .b_data(b_data), .b_tags(b_tags),
      .y_data(raw_data), .y_tags(raw_tags)
   );

   tagflow_inject #(.W(W), .NT(NT), .SW(SW)) u_inject (
      .clk(clk), .rst(rst), .sel(inj_sel), .set_m(inj_set), .clr_m(inj_clr),
      .in_data(raw_data), .in_tags(raw_tags),
      .out_data(fin_data), .out_tags(fin_tags)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            y_data   <= '0;
            y_tags   <= '0;
            org_tags <= '0;
         end else begin
            y_data   <= fin_data;
            y_tags   <= fin_tags;
            org_tags <= raw_tags;
         end
      end

      // R12
      pipe_delay_chk: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> (y_data == $past(fin_data)) && (y_tags == $past(fin_tags)));

      // R12
      reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
         $past(rst) |-> (y_data == '0) && (y_tags == '0) && (org_tags == '0));
   end else begin : g_comb
      assign y_data   = fin_data;
      assign y_tags   = fin_tags;
      assign org_tags = raw_tags;
   end

   tagflow_query #(.W(W), .NT(NT), .SW(SW)) u_q_now (
      .tags(y_tags), .sel(qry_sel), .hit(q_now)
   );

   tagflow_query #(.W(W), .NT(NT), .SW(SW)) u_q_orig (
      .tags(org_tags), .sel(qry_sel), .hit(q_orig)
   );
endmodule

// File: tb/tb_tagflow_unit.sv
`timescale 1ns/1ps
module tb_tagflow_unit;
   localparam int W  = 4;
   localparam int NT = 4;
   localparam int SW = 2;

   logic            clk = 1'b0;
   logic            rst;
   logic [1:0]      op;
   logic [W-1:0]    a_data, b_data, inj_set, inj_clr;
   logic [W*NT-1:0] a_tags, b_tags;
   logic [SW-1:0]   inj_sel, qry_sel;
   logic [W-1:0]    y_data, q_now, q_orig;
   logic [W*NT-1:0] y_tags;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tagflow_unit #(.W(W), .NT(NT), .GB(2), .TAG_GROUPS(8'h50), .REG_OUT(1'b1), .SW(SW)) dut (
      .clk(clk), .rst(rst), .op(op),
      .a_data(a_data), .a_tags(a_tags), .b_data(b_data), .b_tags(b_tags),
      .inj_sel(inj_sel), .inj_set(inj_set), .inj_clr(inj_clr), .qry_sel(qry_sel),
      .y_data(y_data), .y_tags(y_tags), .q_now(q_now), .q_orig(q_orig)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // bench model: groups are tag/2 in this configuration
   task automatic model(output logic [W-1:0] ed, output logic [W*NT-1:0] et,
                        output logic [W-1:0] eq, output logic [W-1:0] eo);
      logic [NT-1:0]   all_t;
      logic [W*NT-1:0] raw;
      all_t = '0;
      for (int i = 0; i < W; i++) all_t |= a_tags[i*NT +: NT] | b_tags[i*NT +: NT];
      for (int i = 0; i < W; i++) begin
         logic ad, bd, pa, pb;
         ad = a_data[i]; bd = b_data[i];
         case (op)
            2'b00: begin ed[i] = ad & bd; pa = bd;  pb = ad;  end
            2'b01: begin ed[i] = ad | bd; pa = !bd; pb = !ad; end
            2'b10: begin ed[i] = ad ^ bd; pa = 1;   pb = 1;   end
            default: begin ed[i] = 0;     pa = 1;   pb = 1;   end
         endcase
         for (int t = 0; t < NT; t++) begin
            logic sa, sb;
            sa = 0; sb = 0;
            for (int u = 0; u < NT; u++) if (u / 2 == t / 2) begin
               sa |= a_tags[i*NT+u];
               sb |= b_tags[i*NT+u];
            end
            if (op == 2'b11) raw[i*NT+t] = all_t[t];
            else raw[i*NT+t] = (a_tags[i*NT+t] & (pa | sb)) | (b_tags[i*NT+t] & (pb | sa));
         end
      end
      et = raw;
      for (int i = 0; i < W; i++) begin
         if (inj_set[i]) et[i*NT + int'(inj_sel)] = 1'b1;
         else if (inj_clr[i]) et[i*NT + int'(inj_sel)] = 1'b0;
         eq[i] = et[i*NT + int'(qry_sel)];
         eo[i] = raw[i*NT + int'(qry_sel)];
      end
   endtask

   // inputs already driven; wait one edge and compare all outputs
   task automatic step_check(input string treq);
      logic [W-1:0] ed, eq, eo;
      logic [W*NT-1:0] et;
      model(ed, et, eq, eo);
      @(posedge clk); #1;
      check("R1 data", 32'(y_data), 32'(ed));
      check(treq, 32'(y_tags), 32'(et));
      check("R10 q_now", 32'(q_now), 32'(eq));
      check("R11 q_orig", 32'(q_orig), 32'(eo));
   endtask

   task automatic clear_inj();
      inj_set = '0; inj_clr = '0; inj_sel = '0; qry_sel = '0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; op = 2'b10;
      a_data = '1; b_data = '0; a_tags = '1; b_tags = '1;
      inj_set = '1; inj_clr = '0; inj_sel = '0; qry_sel = '0;
      repeat (3) @(posedge clk);
      #1;
      // R12 reset clears everything
      check("R12 reset data", 32'(y_data), 0);
      check("R12 reset tags", 32'(y_tags), 0);
      check("R12 reset q_now", 32'(q_now), 0);
      check("R12 reset q_orig", 32'(q_orig), 0);
      @(negedge clk); rst = 1'b0; clear_inj();

      // R5 same-group bypass: AND (0,tag0) & (0,tag1) -> both
      @(negedge clk);
      op = 2'b00; a_data = '0; b_data = '0;
      a_tags = {4{4'b0001}}; b_tags = {4{4'b0010}};
      step_check("R5 group pass");
      check("R5 bit0 tags", 32'(y_tags[3:0]), 32'h3);

      // R6 other group blocked: tag2 on A has no group peer on B
      @(negedge clk);
      a_tags = {4{4'b0101}}; b_tags = {4{4'b0010}};
      step_check("R6 cross group");
      check("R6 bit0 tags", 32'(y_tags[3:0]), 32'h3);

      // R9 set priority over clear, then clear alone
      @(negedge clk);
      op = 2'b10; a_data = 4'b0000; b_data = 4'b0000;
      a_tags = '0; b_tags = {4{4'b1000}};
      inj_sel = 2'd3; inj_set = 4'b0101; inj_clr = 4'b0011; qry_sel = 2'd3;
      step_check("R9 set/clr");
      check("R9 q_now", 32'(q_now), 32'b1101);
      check("R11 q_orig kept", 32'(q_orig), 32'b1111);
      // R10 tag seen while data bit is 0
      check("R10 data zero", 32'(y_data), 0);

      // R12 outputs hold between edges
      @(negedge clk);
      op = 2'b01; a_data = '1; clear_inj();
      #1;
      check("R12 hold data", 32'(y_data), 0);
      @(posedge clk); #1;
      check("R12 after edge", 32'(y_data), 32'hF);

      // sweep: R2 XOR, R3 AND, R4 OR, R7 reserved, R8 injection
      for (int o = 0; o < 4; o++) begin
         for (int k = 0; k < 1024; k++) begin
            @(negedge clk);
            op = 2'(o);
            for (int i = 0; i < W; i++) begin
               int p;
               p = (k + i * 341) % 1024;
               a_data[i] = p[0];
               b_data[i] = p[1];
               a_tags[i*NT +: NT] = 4'(p >> 2);
               b_tags[i*NT +: NT] = 4'(p >> 6);
            end
            inj_set = 4'((k * 5) >> 3);
            inj_clr = 4'((k * 3) >> 2);
            inj_sel = 2'(k >> 4);
            qry_sel = 2'(k >> 6);
            case (o)
               0: step_check("R3 AND tags R8");
               1: step_check("R4 OR tags R8");
               2: step_check("R2 XOR tags R8");
               default: step_check("R7 reserved tags R8");
            endcase
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule